// File: doc/BRIEF.md
# Data Island Packet Parity Inserter

This block takes one auxiliary or InfoFrame packet from a writer and sends it out as a 36-byte stream. The writer supplies three header bytes and twenty-eight body bytes through a byte-write port. The block adds the error-correction parity bytes itself. It adds one after the header and one after each of the four seven-byte body groups. The writer fills in the checksum byte, and the block only reports when that byte is wrong.

Writes go into a staging buffer, and a one-cycle `load_done` marks the staged packet as ready. A ready packet is copied into the transmit buffer only on a frame-sync strobe (`vsync`) that arrives while nothing is being sent. A sink then drains the bytes over a valid/ready stream, and `out_last` marks the final byte. While a packet is being sent, the writer can already stage the next one. That next packet goes out on the first frame-sync after the current packet has finished.

Top module: `dip_ecc_packer`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `csum_err` are all 0.
- R2: Write addresses map as follows: 0 to 2 are header bytes 0 to 2, and 3 to 30 are body bytes 0 to 27. A write to address 31 changes nothing in any packet that is sent.
- R3: A packet is sent only after `load_done` has marked it ready and a `vsync` pulse has then arrived. A `vsync` with no ready packet produces no output.
- R4: The stream order is fixed. It starts with header bytes 0 to 2 and then the header parity. Then, for each group k from 0 to 3, it sends body bytes 7k to 7k+6 followed by the parity of group k. That makes 36 bytes, and `out_last` is high on the 36th byte only.
- R5: Each parity byte is computed over the data bytes of its own group, in stream order, starting from zero. The bits of each byte are taken least significant first. For each data bit d, set f = d XOR r[0] and shift r right by one. If f is 1, r is then XORed with 8'h83. An all-zero group therefore has parity 0.
- R6: A byte leaves only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold their values.
- R7: A `vsync` that arrives during a transmission is ignored. A packet loaded during a transmission is held in staging and is sent only on a later `vsync` that comes after the last byte has gone. `out_valid` stays low for at least one cycle after the last byte.
- R8: When a packet is released, `csum_err` takes the value 1 if the modulo-256 sum of its 31 writer bytes is nonzero, and 0 otherwise. It keeps that value until the next release.
- R9: `out_valid` rises, with header byte 0 on `out_data`, in the cycle right after the clock edge that samples the releasing `vsync`.
- R10: A release clears the ready mark. A further `vsync` without a new `load_done` sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 5 | Byte position for the write |
| wr_data | input | 8 | Byte value to write |
| load_done | input | 1 | Marks the staged packet ready |
| vsync | input | 1 | Frame-sync strobe that releases a ready packet |
| out_valid | output | 1 | Stream byte is present |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the packet |
| csum_err | output | 1 | Checksum of the released packet is not zero |

## Verification
The first byte and the new `csum_err` value are both due one cycle after the clock edge that samples a releasing `vsync`. The bench checks both at the falling edge that follows that rising edge. After that, each byte is due on a cycle where `out_ready` is high. The ready driver and the scoreboard monitor share one falling-edge process, so the monitor pops and compares exactly the bytes that the next rising edge will consume. The bench queues an expected packet only at the moment it releases that packet. Any byte that shows up after an ignored `vsync` therefore meets an empty queue and is reported.

// File: rtl/dip_ecc_packer.sv
module dip_ecc_packer #(
  parameter int HDR_N    = 3,
  parameter int SUB_N    = 4,
  parameter int SUB_DATA = 7,
  parameter int AW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          load_done,
  input  logic          vsync,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          csum_err
);
  localparam int IN_N  = HDR_N + SUB_N * SUB_DATA;
  localparam int OUT_N = HDR_N + 1 + SUB_N * (SUB_DATA + 1);
  localparam int CW    = $clog2(OUT_N);
  localparam int SW    = $clog2(IN_N);

  logic [7:0]    shad [IN_N];
  logic [7:0]    act  [IN_N];
  logic          shad_full, busy;
  logic [CW-1:0] idx;
  logic [7:0]    par, sum;
  logic          is_par, hs, release_pkt;
  logic [SW-1:0] src;
  logic [CW-1:0] jv, grp, off;

  function automatic logic [7:0] bch_step(input logic [7:0] r, input logic [7:0] d);
    logic [7:0] t;
    t = r;
    for (int b = 0; b < 8; b++) begin
      if (d[b] ^ t[0]) t = (t >> 1) ^ 8'h83;
      else             t = t >> 1;
    end
    return t;
  endfunction

  assign release_pkt = vsync && shad_full && !busy;
  assign hs          = busy && out_ready;
  assign out_valid   = busy;
  assign out_last    = busy && (idx == CW'(OUT_N - 1));

  always_comb begin
    is_par = 1'b0;
    src    = '0;
    jv     = '0;
    grp    = '0;
    off    = '0;
    if (idx < CW'(HDR_N + 1)) begin
      is_par = (idx == CW'(HDR_N));
      if (!is_par) src = SW'(idx);
    end else begin
      jv     = idx - CW'(HDR_N + 1);
      grp    = jv / CW'(SUB_DATA + 1);
      off    = jv % CW'(SUB_DATA + 1);
      is_par = (off == CW'(SUB_DATA));
      if (!is_par) src = SW'(HDR_N + int'(grp) * SUB_DATA + int'(off));
    end
  end

  assign out_data = is_par ? par : act[src];

  always_comb begin
    sum = '0;
    for (int i = 0; i < IN_N; i++) sum = sum + shad[i];
  end

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < IN_N)) shad[wr_addr] <= wr_data;
    if (release_pkt) act <= shad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shad_full <= 1'b0;
      busy      <= 1'b0;
      idx       <= '0;
      par       <= '0;
      csum_err  <= 1'b0;
    end else begin
      if (load_done)        shad_full <= 1'b1;
      else if (release_pkt) shad_full <= 1'b0;
      if (release_pkt) begin
        busy     <= 1'b1;
        idx      <= '0;
        par      <= '0;
        csum_err <= (sum != 8'h00);
      end else if (hs) begin
        par <= is_par ? 8'h00 : bch_step(par, out_data);
        if (out_last) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R4
  AST_START_ON_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(vsync)); // R3
  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$rose(out_valid) |-> $stable(csum_err)); // R8
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_last && out_ready |=> !out_valid); // R7
endmodule

// File: tb/dip_ecc_packer_tb.sv
module dip_ecc_packer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       load_done = 1'b0;
  logic       vsync = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, out_last, csum_err;
  logic [7:0] out_data;

  int total = 0;
  int bad = 0;
  logic [8:0] exp_q[$];
  logic [8:0] pend[36];
  logic [7:0] pk[31];
  logic       stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;

  dip_ecc_packer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_done(load_done), .vsync(vsync), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .csum_err(csum_err));

  function automatic logic [7:0] bch_step(input logic [7:0] r, input logic [7:0] d);
    logic [7:0] t;
    t = r;
    for (int b = 0; b < 8; b++) begin
      if (d[b] ^ t[0]) t = (t >> 1) ^ 8'h83;
      else             t = t >> 1;
    end
    return t;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 R5: expected stream built from the ordering and parity rules
  task automatic build_expected();
    logic [7:0] p;
    int n;
    n = 0;
    p = 8'h00;
    for (int i = 0; i < 3; i++) begin
      pend[n] = {1'b0, pk[i]};
      p = bch_step(p, pk[i]);
      n++;
    end
    pend[n] = {1'b0, p};
    n++;
    for (int g = 0; g < 4; g++) begin
      p = 8'h00;
      for (int o = 0; o < 7; o++) begin
        pend[n] = {1'b0, pk[3 + g * 7 + o]};
        p = bch_step(p, pk[3 + g * 7 + o]);
        n++;
      end
      pend[n] = {(g == 3), p};
      n++;
    end
  endtask

  task automatic load_pkt(input logic junk31);
    @(negedge clk);
    for (int i = 0; i < 31; i++) begin
      wr_en = 1'b1; wr_addr = 5'(i); wr_data = pk[i];
      @(negedge clk);
    end
    if (junk31) begin
      wr_addr = 5'd31; wr_data = 8'hFF; // R2: out-of-range write
      @(negedge clk);
    end
    wr_en = 1'b0;
    load_done = 1'b1;
    @(negedge clk);
    load_done = 1'b0;
    build_expected();
  endtask

  task automatic release_pkt(input logic exp_err);
    @(negedge clk);
    for (int i = 0; i < 36; i++) exp_q.push_back(pend[i]);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    chk(out_valid === 1'b1, "R9 valid after vsync", int'(out_valid), 1);
    chk(csum_err === exp_err, "R8 csum_err at release", int'(csum_err), int'(exp_err));
  endtask

  task automatic raw_vsync();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, req, int'(out_valid), 0);
    end
  endtask

  // scoreboard monitor, with the ready driver in the same process
  always @(negedge clk) begin
    logic [8:0] e;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_mode ? lfsr[0] : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R7/R10 unexpected byte", int'(out_data), 0);
      end else begin
        e = exp_q.pop_front();
        chk(out_data === e[7:0], "R4/R5/R6 stream byte", int'(out_data), int'(e[7:0]));
        chk(out_last === e[8], "R4 last flag", int'(out_last), int'(e[8]));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid at reset", int'(out_valid), 0);
    chk(out_last === 1'b0, "R1 last at reset", int'(out_last), 0);
    chk(csum_err === 1'b0, "R1 csum_err at reset", int'(csum_err), 0);
    rst_n = 1'b1;

    raw_vsync();
    quiet(5, "R3 vsync without ready packet");

    // packet A: valid checksum, junk write to address 31
    pk[0] = 8'h82; pk[1] = 8'h02; pk[2] = 8'h0D;
    for (int i = 3; i < 31; i++) pk[i] = 8'(i * 37 + 5);
    s = 8'h00;
    for (int i = 0; i < 31; i++) if (i != 3) s = s + pk[i];
    pk[3] = 8'h00 - s;
    load_pkt(1'b1);
    quiet(20, "R3 held until vsync");
    release_pkt(1'b0);
    chk(out_data === 8'h82, "R9 first byte HB0", int'(out_data), 8'h82);
    wait_drain();

    // packet B: bad checksum, stalled sink, next packet staged mid-transfer
    stall_mode = 1'b1;
    for (int i = 0; i < 31; i++) pk[i] = 8'(i * 11 + 1);
    load_pkt(1'b0);
    release_pkt(1'b1);
    for (int i = 0; i < 31; i++) pk[i] = 8'h00;
    load_pkt(1'b0);
    chk(out_valid === 1'b1, "R7 still sending before mid vsync", int'(out_valid), 1);
    chk(csum_err === 1'b1, "R8 csum_err held", int'(csum_err), 1);
    raw_vsync();
    wait_drain();
    quiet(10, "R7 vsync during transfer ignored");

    // packet C: all zero, parity bytes zero
    stall_mode = 1'b0;
    release_pkt(1'b0);
    wait_drain();
    chk(csum_err === 1'b0, "R8 csum_err after zero packet", int'(csum_err), 0);

    raw_vsync();
    quiet(10, "R10 no resend without reload");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule